// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block collects up to 64 interrupt request lines and presents them to a processor as two active-high levels: a fast line for urgent sources and a normal line for everything else. A rising edge on a request input records that source as pending. Each source carries a 3-bit priority value, and that value, sampled when the edge arrives, decides which line the request joins. Values 0 and 1 select the fast class. Values 2 to 7 select the normal class, where 7 is the most deferrable.

Software talks to the block through a word-addressed 32-bit register file. Pending bits are cleared by writing ones to them. Two enable words gate every source. The priority words pack eight 3-bit fields each. For each class, an entry word returns a vector address for the most urgent enabled pending source: a programmable base plus four times the source number plus one. Because of the plus one, a value of zero means that nothing in that class is pending. With the base at zero, the handler recovers the source number as entry/4 − 1.

Top module: `pvic_top`

## Requirements
- R1: After reset, all pending and enable bits read 0, both lines are low, both entry words read 0, the base and control words read 0, and every priority word reads 0x77777777 (every field is 7).
- R2: A rising edge on request n sets bit n%32 of a pending word in the same clock edge. The fast pending words are at word index 0 and 1 and the normal pending words are at index 2 and 3, with the word chosen as n/32. The fast class is used when the source's priority is 0 or 1. A request held high sets its bit only once.
- R3: Writing a pending word clears exactly the bits written as 1. If a new rising edge on a source lands in the same cycle as the clear of that source's bit, the bit stays set.
- R4: Enable bit n%32 of the word at index 6 (sources 0–31) or index 7 (sources 32–63) gates source n. A disabled source keeps its pending bit, but from the cycle after the enable write it drives neither line and cannot win either entry.
- R5: The fast line (normal line) is high exactly while at least one enabled source is pending in the fast (normal) class.
- R6: The normal entry word at index 5 reads base + 4×(n+1). Here n is the enabled normal-pending source with the smallest priority value, and on a tie the lowest source number wins. The word reads 0 when no such source exists.
- R7: The fast entry word at index 4 follows the same rule as R6 over the enabled fast-pending sources.
- R8: Priority word r sits at index 12+r (r = 0..7). Source k occupies bits [4(k%8)+2 : 4(k%8)] of word k/8. Bit 3 of each nibble reads 0.
- R9: The base word at index 9 holds a full 32-bit value. The control word at index 8 stores bits [1:0], reads 0 in its other bits, and leaves the behaviour unchanged.
- R10: The entry words and lines are combinational in the current pending, enable, priority and base state. A change shows up on the first read after the edge that made it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 64 | Interrupt request lines, one per source, rising edge latched |
| bus_wr_i | input | 1 | Register write strobe, applied at the clock edge |
| bus_widx_i | input | 6 | Register word index (byte offset divided by 4) |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_widx_i, combinational |
| fast_int_o | output | 1 | Fast-class interrupt level, active high |
| norm_int_o | output | 1 | Normal-class interrupt level, active high |

## Verification
The hardest situation to create from the ports is a request edge that arrives in exactly the cycle in which software clears the same pending bit. The stimulus waits until the scoreboard monitor has issued the clear write and raises the request in that same half cycle, so both reach the same clock edge. Ties in priority are the second difficult case. They are built by leaving several sources at the reset priority, then checking that the entry follows the lowest enabled number as higher-numbered or disabled competitors are added or removed.

// File: rtl/pvic_pkg.sv
// Package: shared register word indices for the interrupt controller.
// Assumes a 64-source build (two 32-bit words per pending/enable group).
package pvic_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned CTRL_W = 2;
    localparam int unsigned WIDX_W = 6;

    localparam logic [WIDX_W-1:0] WI_FPEND0 = 6'd0;
    localparam logic [WIDX_W-1:0] WI_NPEND0 = 6'd2;
    localparam logic [WIDX_W-1:0] WI_FENTRY = 6'd4;
    localparam logic [WIDX_W-1:0] WI_NENTRY = 6'd5;
    localparam logic [WIDX_W-1:0] WI_EN0    = 6'd6;
    localparam logic [WIDX_W-1:0] WI_CTRL   = 6'd8;
    localparam logic [WIDX_W-1:0] WI_BASE   = 6'd9;
    localparam logic [WIDX_W-1:0] WI_PRIO0  = 6'd12;

    localparam int unsigned FIELD_STRIDE = 4;
    localparam int unsigned FIELDS_PER_WORD = REG_W / FIELD_STRIDE;
endpackage

// File: rtl/pvic_cfg.sv
// Module: configuration registers (enables, priorities, vector base, control).
// Assumes N_SRC is a multiple of 32; writes land at the clock edge.
module pvic_cfg
    import pvic_pkg::*;
#(
    parameter int unsigned N_SRC = 64,
    parameter int unsigned PRI_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_i,
    input  logic [WIDX_W-1:0]            widx_i,
    input  logic [REG_W-1:0]             wdata_i,
    output logic [N_SRC-1:0]             enable_o,
    output logic [N_SRC-1:0][PRI_W-1:0]  prio_o,
    output logic [REG_W-1:0]             base_o,
    output logic [CTRL_W-1:0]            ctrl_o
);
    localparam int unsigned N_WORDS     = N_SRC / REG_W;
    localparam int unsigned N_PRIO_REGS = N_SRC / FIELDS_PER_WORD;

    // Enable words: software-written gate per source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= '0;
        end else if (wr_i) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (widx_i == WIDX_W'(WI_EN0 + w))
                    enable_o[w*REG_W +: REG_W] <= wdata_i;
            end
        end
    end

    // Priority words: eight packed fields each, all fields reset to the lowest urgency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_o <= '1;
        end else if (wr_i) begin
            for (int r = 0; r < N_PRIO_REGS; r++) begin
                if (widx_i == WIDX_W'(WI_PRIO0 + r)) begin
                    for (int j = 0; j < FIELDS_PER_WORD; j++)
                        prio_o[r*FIELDS_PER_WORD + j] <= wdata_i[j*FIELD_STRIDE +: PRI_W];
                end
            end
        end
    end

    // Vector base and control storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o <= '0;
            ctrl_o <= '0;
        end else if (wr_i) begin
            if (widx_i == WI_BASE) base_o <= wdata_i;
            if (widx_i == WI_CTRL) ctrl_o <= wdata_i[CTRL_W-1:0];
        end
    end
endmodule

// File: rtl/pvic_pending.sv
// Module: request edge detection and pending latches for the fast and normal classes.
// Assumes a source's class is decided by its priority at the moment its edge arrives;
// a set on the same edge as a write-one clear wins.
module pvic_pending #(
    parameter int unsigned N_SRC    = 64,
    parameter int unsigned PRI_W    = 3,
    parameter int unsigned FAST_MAX = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0]            src_req_i,
    input  logic [N_SRC-1:0][PRI_W-1:0] prio_i,
    input  logic [N_SRC-1:0]            fast_clr_i,
    input  logic [N_SRC-1:0]            norm_clr_i,
    output logic [N_SRC-1:0]            fast_pend_o,
    output logic [N_SRC-1:0]            norm_pend_o
);
    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] to_fast;

    // Per-source class select from the current priority field.
    for (genvar i = 0; i < N_SRC; i++) begin : g_class
        assign to_fast[i] = (prio_i[i] <= PRI_W'(FAST_MAX));
    end

    assign rise = src_req_i & ~req_q;

    // Remember last request level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= src_req_i;
    end

    // Pending latches: clear by write-one, set by a new edge (set has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_pend_o <= '0;
            norm_pend_o <= '0;
        end else begin
            fast_pend_o <= (fast_pend_o & ~fast_clr_i) | (rise & to_fast);
            norm_pend_o <= (norm_pend_o & ~norm_clr_i) | (rise & ~to_fast);
        end
    end
endmodule

// File: rtl/pvic_arb.sv
// Module: combinational priority arbiter and vector address generator.
// Smallest priority value wins; ties go to the lowest source number.
// Output is base + 4*(winner+1), or 0 when there is no candidate.
module pvic_arb #(
    parameter int unsigned N_SRC = 64,
    parameter int unsigned PRI_W = 3
) (
    input  logic [N_SRC-1:0]            cand_i,
    input  logic [N_SRC-1:0][PRI_W-1:0] prio_i,
    input  logic [31:0]                 base_i,
    output logic [31:0]                 entry_o
);
    localparam int unsigned IDX_W = $clog2(N_SRC);

    logic             found;
    logic [PRI_W-1:0] best_pri;
    logic [IDX_W-1:0] best_idx;

    // Linear scan; strict less-than keeps the lower index on a tie.
    always_comb begin
        found    = 1'b0;
        best_pri = '1;
        best_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cand_i[i] && (!found || (prio_i[i] < best_pri))) begin
                found    = 1'b1;
                best_pri = prio_i[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    // Vector address formation.
    always_comb begin
        if (found) entry_o = base_i + ((32'(best_idx) + 32'd1) << 2);
        else       entry_o = '0;
    end
endmodule

// File: rtl/pvic_top.sv
// Module: prioritized vectored interrupt controller, top level.
// Holds the register decode and read mux and wires the pending, config and arbiter blocks.
// Assumes the default 64-source map; reads are combinational on the word index.
module pvic_top
    import pvic_pkg::*;
#(
    parameter int unsigned N_SRC    = 64,
    parameter int unsigned PRI_W    = 3,
    parameter int unsigned FAST_MAX = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    src_req_i,
    input  logic                bus_wr_i,
    input  logic [WIDX_W-1:0]   bus_widx_i,
    input  logic [REG_W-1:0]    bus_wdata_i,
    output logic [REG_W-1:0]    bus_rdata_o,
    output logic                fast_int_o,
    output logic                norm_int_o
);
    localparam int unsigned N_WORDS     = N_SRC / REG_W;
    localparam int unsigned N_PRIO_REGS = N_SRC / FIELDS_PER_WORD;
    localparam int unsigned N_CLASS     = 2;

    logic [N_SRC-1:0]              fast_clr, norm_clr;
    logic [N_SRC-1:0]              fast_pend, norm_pend;
    logic [N_SRC-1:0]              enable;
    logic [N_SRC-1:0][PRI_W-1:0]   prio;
    logic [REG_W-1:0]              vec_base;
    logic [CTRL_W-1:0]             ctrl;
    logic [N_CLASS-1:0][N_SRC-1:0] cand;
    logic [N_CLASS-1:0][REG_W-1:0] entry;
    logic [REG_W-1:0]              fast_entry, norm_entry;

    // Write-one-clear masks per pending word.
    for (genvar w = 0; w < N_WORDS; w++) begin : g_clr
        assign fast_clr[w*REG_W +: REG_W] =
            (bus_wr_i && bus_widx_i == WIDX_W'(WI_FPEND0 + w)) ? bus_wdata_i : '0;
        assign norm_clr[w*REG_W +: REG_W] =
            (bus_wr_i && bus_widx_i == WIDX_W'(WI_NPEND0 + w)) ? bus_wdata_i : '0;
    end

    pvic_cfg #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr_i),
        .widx_i   (bus_widx_i),
        .wdata_i  (bus_wdata_i),
        .enable_o (enable),
        .prio_o   (prio),
        .base_o   (vec_base),
        .ctrl_o   (ctrl)
    );

    pvic_pending #(.N_SRC(N_SRC), .PRI_W(PRI_W), .FAST_MAX(FAST_MAX)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src_req_i),
        .prio_i      (prio),
        .fast_clr_i  (fast_clr),
        .norm_clr_i  (norm_clr),
        .fast_pend_o (fast_pend),
        .norm_pend_o (norm_pend)
    );

    assign cand[0] = fast_pend & enable;
    assign cand[1] = norm_pend & enable;

    // One arbiter per class.
    for (genvar c = 0; c < N_CLASS; c++) begin : g_arb
        pvic_arb #(.N_SRC(N_SRC), .PRI_W(PRI_W)) u_arb (
            .cand_i  (cand[c]),
            .prio_i  (prio),
            .base_i  (vec_base),
            .entry_o (entry[c])
        );
    end

    assign fast_entry = entry[0];
    assign norm_entry = entry[1];
    assign fast_int_o = |cand[0];
    assign norm_int_o = |cand[1];

    // Register read mux on the word index.
    always_comb begin
        bus_rdata_o = '0;
        for (int w = 0; w < N_WORDS; w++) begin
            if (bus_widx_i == WIDX_W'(WI_FPEND0 + w)) bus_rdata_o = fast_pend[w*REG_W +: REG_W];
            if (bus_widx_i == WIDX_W'(WI_NPEND0 + w)) bus_rdata_o = norm_pend[w*REG_W +: REG_W];
            if (bus_widx_i == WIDX_W'(WI_EN0 + w))    bus_rdata_o = enable[w*REG_W +: REG_W];
        end
        for (int r = 0; r < N_PRIO_REGS; r++) begin
            if (bus_widx_i == WIDX_W'(WI_PRIO0 + r)) begin
                for (int j = 0; j < FIELDS_PER_WORD; j++)
                    bus_rdata_o[j*FIELD_STRIDE +: PRI_W] = prio[r*FIELDS_PER_WORD + j];
            end
        end
        if (bus_widx_i == WI_FENTRY) bus_rdata_o = fast_entry;
        if (bus_widx_i == WI_NENTRY) bus_rdata_o = norm_entry;
        if (bus_widx_i == WI_BASE)   bus_rdata_o = vec_base;
        if (bus_widx_i == WI_CTRL)   bus_rdata_o = REG_W'(ctrl);
    end
endmodule

// File: rtl/pvic_checker.sv
// Module: assertion checker bound to pvic_top; observes lines, pending state and entries.
// Assumes a vector base below 2^31 for the line/entry agreement checks (no wrap to 0).
module pvic_checker #(
    parameter int unsigned N_SRC = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_req_i,
    input logic [N_SRC-1:0] fast_pend,
    input logic [N_SRC-1:0] norm_pend,
    input logic [31:0]      fast_entry,
    input logic [31:0]      norm_entry,
    input logic [31:0]      vec_base,
    input logic             fast_int_o,
    input logic             norm_int_o
);
    AST_FAST_LINE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_base[31] |-> (fast_int_o == (fast_entry != 32'd0))); // R7
    AST_NORM_LINE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_base[31] |-> (norm_int_o == (norm_entry != 32'd0))); // R6
    AST_NEW_PEND_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (((fast_pend | norm_pend) & ~$past(fast_pend | norm_pend) & ~$past(src_req_i)) == '0)); // R2
    AST_NORM_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_entry != 32'd0) |-> (norm_entry[1:0] == vec_base[1:0])); // R6
    AST_FAST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_entry != 32'd0) |-> (fast_entry[1:0] == vec_base[1:0])); // R7
    AST_FAST_LINE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        fast_int_o |-> (fast_pend != '0)); // R5
    AST_NORM_LINE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        norm_int_o |-> (norm_pend != '0)); // R5
endmodule

bind pvic_top pvic_checker #(.N_SRC(N_SRC)) u_pvic_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req_i  (src_req_i),
    .fast_pend  (fast_pend),
    .norm_pend  (norm_pend),
    .fast_entry (fast_entry),
    .norm_entry (norm_entry),
    .vec_base   (vec_base),
    .fast_int_o (fast_int_o),
    .norm_int_o (norm_int_o)
);

// File: tb/pvic_top_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard of bus operations; driver queues writes and expected reads,
// monitor executes them one per cycle and compares read data.
module pvic_top_tb_top;
    localparam logic [5:0] I_FP0 = 6'd0,  I_FP1 = 6'd1,  I_NP0 = 6'd2, I_NP1 = 6'd3;
    localparam logic [5:0] I_FEN = 6'd4,  I_NEN = 6'd5,  I_EN0 = 6'd6, I_EN1 = 6'd7;
    localparam logic [5:0] I_CTL = 6'd8,  I_BAS = 6'd9,  I_PR0 = 6'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_widx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_int, norm_int;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          wr;
        logic [5:0]  idx;
        logic [31:0] data;
        string       tag;
    } op_t;
    op_t q[$];

    always #4 clk = ~clk;

    pvic_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_req_i   (src),
        .bus_wr_i    (bus_wr),
        .bus_widx_i  (bus_widx),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .fast_int_o  (fast_int),
        .norm_int_o  (norm_int)
    );

    task automatic wr(input logic [5:0] idx, input logic [31:0] d);
        op_t o; o.wr = 1'b1; o.idx = idx; o.data = d; o.tag = "";
        q.push_back(o);
    endtask

    task automatic rd(input logic [5:0] idx, input logic [31:0] exp, input string tag);
        op_t o; o.wr = 1'b0; o.idx = idx; o.data = exp; o.tag = tag;
        q.push_back(o);
    endtask

    task automatic drain();
        wait (q.size() == 0);
        @(posedge clk); #1;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic line_chk(input logic f, input logic n, input string tag);
        checks++;
        if (fast_int !== f || norm_int !== n) begin
            failures++;
            $display("FAIL %s lines fast=%b norm=%b expected fast=%b norm=%b",
                     tag, fast_int, norm_int, f, n);
        end
    endtask

    // Monitor: executes one queued operation per cycle, compares reads.
    initial begin
        forever begin
            @(negedge clk);
            bus_wr = 1'b0;
            if (q.size() > 0) begin
                op_t o;
                o = q.pop_front();
                bus_widx = o.idx;
                if (o.wr) begin
                    bus_wdata = o.data;
                    bus_wr = 1'b1;
                end else begin
                    #1;
                    checks++;
                    if (bus_rdata !== o.data) begin
                        failures++;
                        $display("FAIL %s idx=%0d actual=%h expected=%h",
                                 o.tag, o.idx, bus_rdata, o.data);
                    end
                end
            end
        end
    end

    // Driver: stimulus and expected values.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tick();

        // R1 reset state
        line_chk(1'b0, 1'b0, "R1");
        rd(I_FP0, 32'h0, "R1 fast pend0");
        rd(I_NP1, 32'h0, "R1 norm pend1");
        rd(I_EN0, 32'h0, "R1 enable0");
        rd(I_PR0, 32'h7777_7777, "R1 prio0");
        rd(I_PR0 + 6'd7, 32'h7777_7777, "R1 prio7");
        rd(I_BAS, 32'h0, "R1 base");
        rd(I_CTL, 32'h0, "R1 ctrl");
        rd(I_FEN, 32'h0, "R1 fast entry");
        rd(I_NEN, 32'h0, "R1 norm entry");

        // R8 priority packing: src0..3 = 0,1,2,3
        wr(I_PR0, 32'h7777_3210);
        wr(I_PR0 + 6'd1, 32'hFFFF_FFFF);
        rd(I_PR0, 32'h7777_3210, "R8 prio0 readback");
        rd(I_PR0 + 6'd1, 32'h7777_7777, "R8 nibble bit3 reads 0");
        // R9 base and control
        wr(I_BAS, 32'h0000_0100);
        wr(I_CTL, 32'hFFFF_FFFF);
        rd(I_BAS, 32'h0000_0100, "R9 base");
        rd(I_CTL, 32'h0000_0003, "R9 ctrl");
        drain();

        // R2 latch into normal class while disabled (R4)
        src[2] = 1'b1; src[33] = 1'b1; tick();
        src[2] = 1'b0; src[33] = 1'b0;
        rd(I_NP0, 32'h0000_0004, "R2 norm pend0");
        rd(I_NP1, 32'h0000_0002, "R2 norm pend1");
        rd(I_FP0, 32'h0, "R2 fast pend0 untouched");
        rd(I_NEN, 32'h0, "R4 disabled no entry");
        drain();
        line_chk(1'b0, 1'b0, "R4 disabled lines low");

        // R5/R6 enable all
        wr(I_EN0, 32'hFFFF_FFFF);
        wr(I_EN1, 32'hFFFF_FFFF);
        rd(I_NEN, 32'h0000_010C, "R6 prio2 beats prio7");
        drain();
        line_chk(1'b0, 1'b1, "R5 normal line");

        // R2/R7 fast class
        src[0] = 1'b1; src[1] = 1'b1; tick();
        src[0] = 1'b0; src[1] = 1'b0;
        rd(I_FP0, 32'h0000_0003, "R2 fast pend0");
        rd(I_FEN, 32'h0000_0104, "R7 fast entry src0");
        rd(I_NEN, 32'h0000_010C, "R6 normal unaffected");
        drain();
        line_chk(1'b1, 1'b1, "R5 both lines");

        // R3/R6 clear src2, tie among prio 7
        wr(I_NP0, 32'h0000_0004);
        rd(I_NP0, 32'h0, "R3 clear src2");
        rd(I_NEN, 32'h0000_0188, "R6 src33 wins");
        drain();
        src[40] = 1'b1; tick(); src[40] = 1'b0;
        rd(I_NP1, 32'h0000_0102, "R2 src40 latched");
        rd(I_NEN, 32'h0000_0188, "R6 tie lower index");
        // R4 disable src33
        wr(I_EN1, 32'hFFFF_FFFD);
        rd(I_NEN, 32'h0000_01A4, "R4 disabled loses, src40 wins");
        rd(I_NP1, 32'h0000_0102, "R4 pending kept");
        // R3 partial clear
        wr(I_NP1, 32'h0000_0100);
        rd(I_NP1, 32'h0000_0002, "R3 partial clear");
        rd(I_NEN, 32'h0, "R6 none enabled");
        drain();
        line_chk(1'b1, 1'b0, "R5 normal line drops");

        // R2 held-high request does not re-latch
        src[50] = 1'b1; tick();
        rd(I_NP1, 32'h0004_0002, "R2 src50 latched");
        rd(I_NEN, 32'h0000_01CC, "R6 src50 entry");
        wr(I_NP1, 32'h0004_0000);
        drain();
        tick(); tick();
        rd(I_NP1, 32'h0000_0002, "R2 held level no relatch");
        drain();
        src[50] = 1'b0;

        // R3 set wins over same-cycle clear
        wr(I_NP1, 32'h1000_0000);
        wait (q.size() == 0);
        src[60] = 1'b1;
        tick();
        src[60] = 1'b0;
        rd(I_NP1, 32'h1000_0002, "R3 set beats clear");
        rd(I_NEN, 32'h0000_01F4, "R6 src60 entry");

        // R7 fast entry after clearing src0, then base 0
        wr(I_FP0, 32'h0000_0001);
        rd(I_FP0, 32'h0000_0002, "R3 fast clear");
        rd(I_FEN, 32'h0000_0108, "R7 src1 entry");
        wr(I_BAS, 32'h0);
        rd(I_FEN, 32'h0000_0008, "R7 base0 entry");
        rd(I_NEN, 32'h0000_00F4, "R10 base change immediate");
        // R10/R4 disable src1, next read sees it
        wr(I_EN0, 32'hFFFF_FFFD);
        rd(I_FEN, 32'h0, "R10 fast entry after disable");
        rd(I_FP0, 32'h0000_0002, "R4 fast pending kept");
        drain();
        line_chk(1'b0, 1'b1, "R10 lines after disable");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule